// File: doc/BRIEF.md
# Consecutive-Run Output Filter

This block cleans up a noisy serial bit stream. On each clock where its strobe is high it accepts one sample. It holds a single filtered output bit, and it changes that bit only after it has seen the opposite value on three accepted samples in a row. A single sample that agrees with the present output, arriving before the run is complete, cancels the run. The output therefore has hysteresis: short bursts of one or two opposing samples are ignored.

The filter has no fixed start level. After reset it waits for the first accepted sample and takes its output level from that sample. A build parameter selects one of two output timings. In the early-output variant, the output is decided combinationally and moves in the same cycle as the third opposing sample. In the registered variant, the output is decoded from the state register alone and moves one clock later.

Top module: `runflt_top`

## Requirements
- R1: After a synchronous reset, and until the first accepted sample, `filt_out` is 0 in both timing variants. This level is a placeholder and does not act as a seed.
- R2: The first accepted sample after reset seeds the output level and starts an empty opposing run. With `MEALY`=1 the output shows the seed in that sample's cycle. With `MEALY`=0 it shows the seed from the next cycle on.
- R3: While the output is 0, three consecutive accepted samples of value 1 switch the output to 1.
- R4: While the output is 1, three consecutive accepted samples of value 0 switch the output to 0.
- R5: An accepted sample equal to the present output clears the opposing run. A switch then needs three new opposing samples.
- R6: A cycle with `smp_valid` low changes neither the state nor the output. A partial opposing run survives any number of such cycles.
- R7: Fewer than three opposing samples leave the output unchanged. After a switch the run starts from zero, so no opposing sample of the earlier run counts toward the next switch.
- R8: With `MEALY`=1, in every cycle `filt_out` equals the level the filter will hold after the current sample, and equals the stored level when `smp_valid` is low.
- R9: With `MEALY`=0, `filt_out` depends only on the state register. A switch appears on the clock edge after the third opposing sample.
- R10: Asserting `rst` for one clock in the middle of operation discards the stored level and the run. The next accepted sample seeds the output again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | High when `smp_bit` carries a sample for this cycle |
| smp_bit | input | 1 | Serial input sample |
| filt_out | output | 1 | Filtered output level |

## Verification
The hardest case to reach from the ports is a partial opposing run that is broken up by idle cycles and then either completed or cancelled. Such a run must reach exactly three without losing or gaining a count. It only appears when specific combinations of strobe and data line up. The bench reaches it by sweeping every 6-bit strobe mask against every 6-bit data pattern after a fresh reset, and every 8-sample data sequence with the strobe held high. A bench-side counter model predicts the output for both timing variants side by side.

// File: rtl/runflt_pkg.sv
package runflt_pkg;

  localparam int RF_RUN_LEN = 3;
  localparam int RF_CNT_W   = $clog2(RF_RUN_LEN + 1);
  localparam int RF_ST_W    = RF_CNT_W + 1;
  localparam logic [RF_CNT_W-1:0] RF_LAST = RF_CNT_W'(RF_RUN_LEN - 1);

  // Encoding: bit 2 is the held level, bits 1:0 hold run+1 (00 means idle).
  // Code 3'b100 is unused and recovers to idle.
  typedef enum logic [RF_ST_W-1:0] {
    RF_IDLE = 3'b000,
    RF_LO0  = 3'b001,
    RF_LO1  = 3'b010,
    RF_LO2  = 3'b011,
    RF_HI0  = 3'b101,
    RF_HI1  = 3'b110,
    RF_HI2  = 3'b111
  } rf_state_t;

  function automatic logic st_pol(rf_state_t s);
    return s[RF_ST_W-1];
  endfunction

  function automatic logic [RF_CNT_W-1:0] st_run(rf_state_t s);
    return s[RF_CNT_W-1:0] - RF_CNT_W'(1);
  endfunction

  function automatic rf_state_t st_make(logic pol, logic [RF_CNT_W-1:0] run);
    return rf_state_t'({pol, run + RF_CNT_W'(1)});
  endfunction

endpackage

// File: rtl/runflt_next.sv
module runflt_next
  import runflt_pkg::*;
(
  input  rf_state_t cur_i,
  input  logic      valid_i,
  input  logic      bit_i,
  output rf_state_t nxt_o,
  output logic      seed_evt_o,
  output logic      switch_evt_o,
  output logic      clear_evt_o,
  output logic      count_evt_o
);

  logic                pol;
  logic [RF_CNT_W-1:0] run;

  assign pol = st_pol(cur_i);
  assign run = st_run(cur_i);

  always_comb begin
    nxt_o        = cur_i;
    seed_evt_o   = 1'b0;
    switch_evt_o = 1'b0;
    clear_evt_o  = 1'b0;
    count_evt_o  = 1'b0;
    case (cur_i)
      RF_IDLE: begin
        if (valid_i) begin
          nxt_o      = st_make(bit_i, '0);
          seed_evt_o = 1'b1;
        end
      end
      RF_LO0, RF_LO1, RF_LO2, RF_HI0, RF_HI1, RF_HI2: begin
        if (valid_i) begin
          if (bit_i == pol) begin
            nxt_o       = st_make(pol, '0);
            clear_evt_o = 1'b1;
          end else if (run == RF_LAST) begin
            nxt_o        = st_make(~pol, '0);
            switch_evt_o = 1'b1;
          end else begin
            nxt_o       = st_make(pol, run + RF_CNT_W'(1));
            count_evt_o = 1'b1;
          end
        end
      end
      default: nxt_o = RF_IDLE;
    endcase
  end

endmodule

// File: rtl/runflt_state_reg.sv
module runflt_state_reg
  import runflt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rf_state_t nxt_i,
  output rf_state_t cur_o
);

  always_ff @(posedge clk) begin
    if (rst) cur_o <= RF_IDLE;
    else     cur_o <= nxt_i;
  end

  // R10: reset lands in the idle state
  a_r10_reset_idle: assert property (@(posedge clk) rst |=> cur_o == RF_IDLE);

endmodule

// File: rtl/runflt_outsel.sv
module runflt_outsel #(
  parameter bit MEALY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic cur_pol_i,
  input  logic nxt_pol_i,
  input  logic switch_evt_i,
  input  logic seed_evt_i,
  output logic out_o
);

  generate
    if (MEALY) begin : g_early
      assign out_o = valid_i ? nxt_pol_i : cur_pol_i;
      // R8: the switching sample already shows the new level
      a_r8_early_switch: assert property (@(posedge clk) disable iff (rst)
        switch_evt_i |-> out_o != cur_pol_i);
    end else begin : g_late
      assign out_o = cur_pol_i;
      // R9: without a seed or switch last cycle the output holds
      a_r9_late_stable: assert property (@(posedge clk) disable iff (rst)
        !(switch_evt_i || seed_evt_i) |=> $stable(out_o));
      // R9: the switch shows one edge later
      a_r9_late_switch: assert property (@(posedge clk) disable iff (rst)
        switch_evt_i |=> out_o != $past(out_o));
    end
  endgenerate

endmodule

// File: rtl/runflt_top.sv
module runflt_top
  import runflt_pkg::*;
#(
  parameter bit MEALY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_valid,
  input  logic smp_bit,
  output logic filt_out
);

  rf_state_t cur_st;
  rf_state_t nxt_st;
  logic      seed_evt;
  logic      switch_evt;
  logic      clear_evt;
  logic      count_evt;

  runflt_next u_next (
    .cur_i        (cur_st),
    .valid_i      (smp_valid),
    .bit_i        (smp_bit),
    .nxt_o        (nxt_st),
    .seed_evt_o   (seed_evt),
    .switch_evt_o (switch_evt),
    .clear_evt_o  (clear_evt),
    .count_evt_o  (count_evt)
  );

  runflt_state_reg u_state (
    .clk   (clk),
    .rst   (rst),
    .nxt_i (nxt_st),
    .cur_o (cur_st)
  );

  runflt_outsel #(.MEALY(MEALY)) u_out (
    .clk          (clk),
    .rst          (rst),
    .valid_i      (smp_valid),
    .cur_pol_i    (st_pol(cur_st)),
    .nxt_pol_i    (st_pol(nxt_st)),
    .switch_evt_i (switch_evt),
    .seed_evt_i   (seed_evt),
    .out_o        (filt_out)
  );

  // R2: the first accepted sample seeds the level with an empty run
  a_r2_seed: assert property (@(posedge clk) disable iff (rst)
    (cur_st == RF_IDLE && smp_valid) |=>
      (st_pol(cur_st) == $past(smp_bit) && st_run(cur_st) == '0));

  // R3: third opposing 1 from a low level raises the output
  a_r3_rise: assert property (@(posedge clk) disable iff (rst)
    (cur_st == RF_LO2 && smp_valid && smp_bit) |=> cur_st == RF_HI0);

  // R4: third opposing 0 from a high level lowers the output
  a_r4_fall: assert property (@(posedge clk) disable iff (rst)
    (cur_st == RF_HI2 && smp_valid && !smp_bit) |=> cur_st == RF_LO0);

  // R5: an agreeing sample empties the run
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clear_evt |=> (st_run(cur_st) == '0 && st_pol(cur_st) == $past(smp_bit)));

  // R6: idle cycles freeze the state
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && cur_st != RF_IDLE) |=> $stable(cur_st));

  // R7: a partial run keeps the level and grows by one
  a_r7_count: assert property (@(posedge clk) disable iff (rst)
    count_evt |=> (st_pol(cur_st) == $past(st_pol(cur_st)) &&
                   st_run(cur_st) == $past(st_run(cur_st)) + RF_CNT_W'(1)));

  // R7: a switch starts the next run from zero
  a_r7_fresh_run: assert property (@(posedge clk) disable iff (rst)
    switch_evt |=> st_run(cur_st) == '0);

  // at most one kind of event per cycle
  a_r7_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seed_evt, switch_evt, clear_evt, count_evt}));

endmodule

// File: tb/test_runflt_top.sv
module test_runflt_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic v   = 1'b0;
  logic d   = 1'b0;
  logic out_early, out_late;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model: seeded flag, held level, opposing run length
  bit m_seeded;
  bit m_pol;
  int m_cnt;

  runflt_top #(.MEALY(1'b1)) i_runflt_top (
    .clk(clk), .rst(rst), .smp_valid(v), .smp_bit(d), .filt_out(out_early));

  runflt_top #(.MEALY(1'b0)) i_runflt_top_late (
    .clk(clk), .rst(rst), .smp_valid(v), .smp_bit(d), .filt_out(out_late));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; v = 1'b0; d = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_seeded = 1'b0; m_pol = 1'b0; m_cnt = 0;
  endtask

  // one sample: drive at negedge, compare 2 ns later, then commit model
  task automatic step(bit vi, bit di);
    bit    ns, np;
    int    nc;
    string tag;
    @(negedge clk);
    v = vi; d = di;
    #2;
    ns = m_seeded; np = m_pol; nc = m_cnt;
    if (!vi) tag = "R6";
    else if (!m_seeded) begin ns = 1'b1; np = di; nc = 0; tag = "R2"; end
    else if (di == m_pol) begin nc = 0; tag = "R5"; end
    else begin
      nc = m_cnt + 1;
      if (nc >= 3) begin
        tag = m_pol ? "R4" : "R3";
        np  = ~m_pol;
        nc  = 0;
      end else tag = "R7";
    end
    chk({"R8/", tag}, out_early, vi ? np : m_pol);
    chk({"R9/", tag}, out_late, m_pol);
    m_seeded = ns; m_pol = np; m_cnt = nc;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    #2;
    chk("R1 early", out_early, 1'b0);
    chk("R1 late", out_late, 1'b0);
    step(1'b0, 1'b1);
    chk("R1 idle hold", out_early, 1'b0);

    // R7: switch, two opposing, then the third
    step(1'b1, 1'b0);
    step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b1);
    chk("R3 early level", out_early, 1'b1);
    step(1'b1, 1'b0); step(1'b1, 1'b0);
    chk("R7 two opposing", out_early, 1'b1);
    step(1'b1, 1'b0);
    chk("R4 third opposing", out_early, 1'b0);

    // R10: reset mid-operation re-seeds
    step(1'b1, 1'b1); step(1'b1, 1'b1);
    do_reset();
    #2;
    chk("R10 cleared", out_late, 1'b0);
    step(1'b1, 1'b1);
    chk("R10 reseed", out_early, 1'b1);
    step(1'b0, 1'b0);
    chk("R10 reseed late", out_late, 1'b1);

    // sweep all 8-sample data sequences, strobe high
    for (int s = 0; s < 256; s++) begin
      logic [7:0] dm;
      dm = 8'(s);
      do_reset();
      for (int i = 0; i < 8; i++) step(1'b1, dm[i]);
    end

    // sweep every strobe mask against every data pattern
    for (int vm = 0; vm < 64; vm++) begin
      for (int dm = 0; dm < 64; dm++) begin
        logic [5:0] vb, db;
        vb = 6'(vm);
        db = 6'(dm);
        do_reset();
        for (int i = 0; i < 6; i++) step(vb[i], db[i]);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule